// File: doc/BRIEF.md
# SPI Master Baud Clock Engine

This block is the shifting core of an SPI master. It runs on a low-speed peripheral clock. A programmable divider derives the serial clock period from a 7-bit setting, with a floor of four peripheral clocks. A start pulse takes a snapshot of the configuration and the transmit word. The engine then shifts a character of 1 to 16 bits out on MOSI, most significant bit first, and collects the same number of bits from MISO into a receive word.

The serial clock polarity sets the idle level of SCLK. The phase setting selects when data is launched. With phase 1, each bit is launched on the first SCLK edge of its period and sampled on the second edge. With phase 0, each bit is presented before its first edge, which samples MISO. When the divisor is odd, the two halves of the SCLK period differ by one peripheral clock. The half spent at the non-idle level is always the shorter one. The block has a busy flag, a one-cycle done pulse and a receive data output. Software-facing registers, chip select and buffering are left to the surrounding logic.

Top module: `spi_baud_master`

## Requirements
- R1: The SCLK period P, in peripheral clocks, is divSet+1 when divSet is 3 or more, and exactly 4 when divSet is 0, 1 or 2. P therefore ranges from 4 to 128.
- R2: In each SCLK period, the half at the non-idle level lasts floor(P/2) clocks and the half at the idle level lasts P-floor(P/2) clocks. For odd P this makes the high half shorter when cpol=0 and the low half shorter when cpol=1.
- R3: While not busy, SCLK sits at the idle level: low for cpol=0 and high for cpol=1. It follows the cpol input one clock later.
- R4: With cpha=1, each bit period starts at the level opposite the idle level. MOSI changes only on the edge that leaves the idle level. MISO is sampled on the edge that returns to it, half a period later.
- R5: With cpha=0, each bit period starts at the idle level with its MOSI bit already valid. MISO is sampled on the edge that leaves idle. MOSI changes only on the edge back to idle.
- R6: The charLen field value L (0 to 15) gives a character of L+1 bits. txWord[L] is sent first and txWord[0] last. MOSI is 0 while not busy.
- R7: In the done cycle, rxWord takes the L+1 sampled bits. The first sampled bit goes to bit L and the last to bit 0, and all higher bits are 0. rxWord then holds its value until the next done.
- R8: A start pulse is accepted only when the block is idle and masterEn is 1. busy rises on the next clock. A start pulse while busy, or with masterEn at 0, has no effect.
- R9: busy stays high for exactly (L+1)*P clocks. done is high for exactly one clock, in the first cycle with busy low, and at that point SCLK is at its idle level.
- R10: Changes to divSet, cpol, cpha, charLen or txWord while busy do not alter the character in progress.
- R11: After reset, busy, done, SCLK, MOSI and rxWord are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterEn | input | 1 | Allows transfers to be started as bus master |
| divSet | input | 7 | Baud divider setting |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | 1 = launch each bit on the first edge of its period |
| charLen | input | 4 | Character length minus one |
| txWord | input | 16 | Word to transmit |
| start | input | 1 | Begin a transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxWord | output | 16 | Last received character, right aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle width of done and its coincidence with the fall of busy, start acceptance and rejection under masterEn, the idle SCLK level tracking cpol, and rxWord holding between done pulses. Other behaviour is shown only by the bench's scenarios, which compare against a time-indexed reference model. This covers the period arithmetic, including the divide-by-4 floor and the 128-clock ceiling, and the uneven high and low halves for odd divisors under both polarities. It also covers which SCLK edge launches and which samples in each phase mode, MSB-first ordering at lengths 1, 8 and 16, and the configuration freeze during a character.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

  // Strobes passed from the sequencer to the shift datapath.
  typedef struct packed {
    logic active;  // a character is in flight
    logic load;    // capture transmit word, clear receive shifter
    logic sample;  // shift MISO into the receive shifter
    logic shift;   // advance the transmit shifter to the next bit
    logic finish;  // publish the received character
  } ctlStrobe_t;

endpackage

// File: rtl/spi_baud_ctrl.sv
module spi_baud_ctrl
  import spi_baud_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterEn,
  input  logic             start,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] divSet,
  input  logic [LEN_W-1:0] charLen,
  output ctlStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             sclk
);

  localparam int PER_W      = DIV_W + 1;
  localparam int MIN_SET    = 3;
  localparam int MIN_PERIOD = 4;

  // Period from the setting, with the small-setting floor.
  function automatic logic [PER_W-1:0] periodOf(input logic [DIV_W-1:0] s);
    if (s < DIV_W'(MIN_SET)) return PER_W'(MIN_PERIOD);
    return PER_W'(s) + PER_W'(1);
  endfunction

  // Non-idle half is the shorter one when the period is odd.
  function automatic logic [PER_W-1:0] activeLen(input logic [PER_W-1:0] p);
    return {1'b0, p[PER_W-1:1]};
  endfunction

  function automatic logic [PER_W-1:0] idleLen(input logic [PER_W-1:0] p);
    return p - activeLen(p);
  endfunction

  // Phase 1 opens each bit at the non-idle level, phase 0 at the idle level.
  function automatic logic [PER_W-1:0] firstLen(input logic [PER_W-1:0] p, input logic ph);
    return ph ? activeLen(p) : idleLen(p);
  endfunction

  function automatic logic [PER_W-1:0] secondLen(input logic [PER_W-1:0] p, input logic ph);
    return ph ? idleLen(p) : activeLen(p);
  endfunction

  logic             half;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] cfgPer;
  logic             cfgPol;
  logic             cfgPha;
  logic [LEN_W-1:0] bitCnt;
  logic [PER_W-1:0] livePer;
  logic             halfEnd;
  logic             accept;

  assign livePer = periodOf(divSet);
  assign accept  = !busy && start && masterEn;
  assign halfEnd = busy && (cnt == '0);

  always_comb begin
    strobe.active = busy;
    strobe.load   = accept;
    strobe.sample = halfEnd && !half;
    strobe.shift  = halfEnd && half && (bitCnt != '0);
    strobe.finish = halfEnd && half && (bitCnt == '0);
  end

  // Configuration snapshot: tracks the inputs only while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPer <= PER_W'(MIN_PERIOD);
      cfgPol <= 1'b0;
      cfgPha <= 1'b0;
    end else if (!busy) begin
      cfgPer <= livePer;
      cfgPol <= cpol;
      cfgPha <= cpha;
    end
  end

  // Half-period sequencer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      half   <= 1'b0;
      cnt    <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (accept) begin
        busy   <= 1'b1;
        half   <= 1'b0;
        cnt    <= firstLen(livePer, cpha) - PER_W'(1);
        bitCnt <= charLen;
      end else if (halfEnd) begin
        if (!half) begin
          half <= 1'b1;
          cnt  <= secondLen(cfgPer, cfgPha) - PER_W'(1);
        end else if (bitCnt == '0) begin
          busy <= 1'b0;
          half <= 1'b0;
        end else begin
          half   <= 1'b0;
          cnt    <= firstLen(cfgPer, cfgPha) - PER_W'(1);
          bitCnt <= bitCnt - LEN_W'(1);
        end
      end else if (busy) begin
        cnt <= cnt - PER_W'(1);
      end
    end
  end

  assign sclk = busy ? (cfgPol ^ half ^ cfgPha) : cfgPol;

endmodule

// File: rtl/spi_baud_dp.sv
module spi_baud_dp
  import spi_baud_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [LEN_W-1:0]  charLen,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);

  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic [LEN_W-1:0]  alignAmt;

  // Left-align the character so its first bit sits at the MSB.
  assign alignAmt = TOP_IDX - charLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      rxWord <= '0;
    end else begin
      if (strobe.load) begin
        txSh <= txWord << alignAmt;
        rxSh <= '0;
      end else begin
        if (strobe.shift)  txSh <= {txSh[DATA_W-2:0], 1'b0};
        if (strobe.sample) rxSh <= {rxSh[DATA_W-2:0], miso};
      end
      if (strobe.finish) rxWord <= rxSh;
    end
  end

  assign mosi = strobe.active ? txSh[DATA_W-1] : 1'b0;

endmodule

// File: rtl/spi_baud_master.sv
module spi_baud_master
  import spi_baud_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       masterEn,
  input  logic [DIV_W-1:0]           divSet,
  input  logic                       cpol,
  input  logic                       cpha,
  input  logic [$clog2(DATA_W)-1:0]  charLen,
  input  logic [DATA_W-1:0]          txWord,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic [DATA_W-1:0]          rxWord,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso
);

  localparam int LEN_W = $clog2(DATA_W);

  ctlStrobe_t strobe;

  spi_baud_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .masterEn (masterEn),
    .start    (start),
    .cpol     (cpol),
    .cpha     (cpha),
    .divSet   (divSet),
    .charLen  (charLen),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk)
  );

  spi_baud_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .charLen (charLen),
    .txWord  (txWord),
    .miso    (miso),
    .mosi    (mosi),
    .rxWord  (rxWord)
  );

endmodule

// File: rtl/spi_baud_master_chk.sv
module spi_baud_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic              cpol,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic [DATA_W-1:0] rxWord
);

  // Set once one edge has passed out of reset, so $past is meaningful.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $fell(busy)) |-> done);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && masterEn && !busy) |=> busy);

  // R8
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !masterEn && !busy) |=> !busy);

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !busy && $past(!busy)) |-> (sclk == $past(cpol)));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !done) |-> $stable(rxWord));

endmodule

bind spi_baud_master spi_baud_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .masterEn (masterEn),
  .cpol     (cpol),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .sclk     (sclk),
  .rxWord   (rxWord)
);

// File: tb/spi_baud_master_tb.sv
`timescale 1ns/1ps
module spi_baud_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterEn = 1'b1;
  logic [6:0]  divSet = '0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [3:0]  charLen = '0;
  logic [15:0] txWord = '0;
  logic        start = 1'b0;
  logic        busy, done, sclk, mosi;
  logic [15:0] rxWord;
  logic        miso;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_baud_master u_dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .divSet(divSet),
    .cpol(cpol), .cpha(cpha), .charLen(charLen), .txWord(txWord),
    .start(start), .busy(busy), .done(done), .rxWord(rxWord),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // MISO stimulus: pseudo-random bit stream, changed away from the active edge.
  assign miso = lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference, indexed by clocks since the start was accepted.
  bit          mBusy, mDone, mPol, mPha;
  int          mP, mL, mT, mH0;
  logic [15:0] mTx, mRx, mRxOut;

  function automatic int periodFor(input int s);
    return (s <= 2) ? 4 : s + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mPol = 0; mPha = 0; mRxOut = '0; mRx = '0;
      mP = 4; mL = 0; mT = 0; mH0 = 2; mTx = '0;
    end else if (mBusy) begin
      if ((mT % mP) == mH0 - 1) mRx = {mRx[14:0], miso};
      mT++;
      if (mT == (mL + 1) * mP) begin
        mBusy = 0; mDone = 1; mRxOut = mRx;
      end
    end else begin
      mDone = 0;
      mPol  = cpol;
      if (start && masterEn) begin
        mPha = cpha; mP = periodFor(int'(divSet)); mL = int'(charLen);
        mTx = txWord; mT = 0; mRx = '0; mBusy = 1;
        mH0 = mPha ? (mP / 2) : (mP - mP / 2);
      end
    end
  end

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eSclk, eMosi;
      eSclk = mBusy ? (mPol ^ ((mT % mP) >= mH0) ^ mPha) : mPol;
      eMosi = mBusy ? mTx[mL - mT / mP] : 1'b0;
      check(busy == mBusy, "R8", "busy", int'(busy), int'(mBusy));
      check(done == mDone, "R9", "done", int'(done), int'(mDone));
      check(sclk == eSclk, mBusy ? "R1" : "R3", "sclk", int'(sclk), int'(eSclk));
      check(mosi == eMosi, "R6", "mosi", int'(mosi), int'(eMosi));
      check(rxWord == mRxOut, "R7", "rxWord", int'(rxWord), int'(mRxOut));
    end
  end

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // One character; meddle=1 disturbs inputs while busy.
  task automatic xfer(input int div, input bit pol, input bit pha, input int len,
                      input logic [15:0] tx, input bit meddle);
    int p, n, act;
    bit first, prevSclk, prevMosi;
    p = periodFor(div);
    @(negedge clk);
    divSet = 7'(div); cpol = pol; cpha = pha; charLen = 4'(len); txWord = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; act = 0; first = 1;
    while (busy) begin
      n++;
      if (sclk != pol) act++;
      if (!first && mosi != prevMosi) begin
        if (pha) check(sclk != pol && prevSclk == pol, "R4", "launch edge", int'(sclk), int'(!pol));
        else     check(sclk == pol && prevSclk != pol, "R5", "launch edge", int'(sclk), int'(pol));
      end
      first = 0; prevSclk = sclk; prevMosi = mosi;
      if (meddle && n == 3) begin
        divSet = 7'(div + 20); cpol = !pol; cpha = !pha; charLen = 4'(len + 3);
        txWord = ~tx; start = 1'b1;
      end
      if (meddle && n == 4) start = 1'b0;
      @(negedge clk);
    end
    check(n == (len + 1) * p, meddle ? "R10" : "R1", "busy cycles", n, (len + 1) * p);
    check(act == (len + 1) * (p / 2), "R2", "non-idle cycles", act, (len + 1) * (p / 2));
    check(done == 1'b1, "R9", "done after busy", int'(done), 1);
    check(sclk == pol, "R9", "sclk idle at done", int'(sclk), int'(pol));
    check(rxWord == mRxOut, "R7", "rx at done", int'(rxWord), int'(mRxOut));
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", int'(done), 0);
    cpol = pol; start = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 1'b0, "R11", "busy", int'(busy), 0);
    check(done == 1'b0, "R11", "done", int'(done), 0);
    check(sclk == 1'b0, "R11", "sclk", int'(sclk), 0);
    check(mosi == 1'b0, "R11", "mosi", int'(mosi), 0);
    check(rxWord == 16'h0, "R11", "rxWord", int'(rxWord), 0);

    xfer(7,   0, 1, 7,  16'h00A5, 0);  // P=8
    xfer(0,   1, 1, 7,  16'h003C, 0);  // floor to 4
    xfer(1,   0, 1, 3,  16'h000A, 0);
    xfer(2,   1, 0, 3,  16'h0005, 0);
    xfer(3,   0, 1, 5,  16'h002A, 0);  // P=4 from the formula
    xfer(4,   0, 1, 7,  16'h0055, 0);  // odd P=5, pol 0
    xfer(4,   1, 1, 7,  16'h00AA, 0);  // odd P=5, pol 1
    xfer(6,   1, 0, 9,  16'h02AA, 0);  // odd P=7, phase 0
    xfer(5,   0, 0, 15, 16'hA5A5, 0);  // 16-bit character
    xfer(9,   0, 1, 0,  16'h0001, 0);  // 1-bit character
    xfer(127, 1, 1, 1,  16'h0002, 0);  // P=128
    xfer(10,  0, 1, 11, 16'h0ABC, 1);  // R10 changes while busy

    // R8 start refused without master enable
    @(negedge clk);
    masterEn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R8", "start with masterEn=0", int'(busy), 0);
    masterEn = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R8", "no late start", int'(busy), 0);

    // R3 idle SCLK follows polarity
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R3", "idle high", int'(sclk), 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R3", "idle low", int'(sclk), 0);

    summary();
  end

endmodule